// File: doc/BRIEF.md
# Iterative Integer Multiplier

This block multiplies two full-word integers for an integer execution unit, one bit of the multiplier per clock. A caller puts two operands and a 7-bit operation code on the inputs and pulses `start`. The block then runs a shift-and-add sequence over the operand magnitudes and builds the whole double-width product. In its last cycle it fixes the sign, picks the part of the product the operation asks for, raises `done` for one cycle and sets `ovf` where the operation checks for overflow.

There are five operations. The half-word multiply works on the signed low halves of the operands and returns a sign-extended half-word result. The full-word multiply returns the low word of the product. The unsigned high multiply returns the upper word of the unsigned double-width product. Two checked forms repeat the half-word and full-word multiplies and raise an overflow flag when the dropped product bits are more than a sign extension of the result. The block handles one operation at a time. A `start` that arrives while it is busy has no effect.

Top module: `imul_iter`

## Requirements
- R1: While reset is active and after it is released, `busy`, `done` and `ovf` are 0 and `result` is 0.
- R2: Code 0x00 (half-word multiply) sign-extends bits 31:0 of each operand, multiplies them, and returns bits 31:0 of the product sign-extended to 64 bits, with `ovf` 0.
- R3: Code 0x20 (full-word multiply) returns bits 63:0 of the product, with `ovf` 0.
- R4: Code 0x30 (unsigned high multiply) treats both operands as unsigned and returns bits 127:64 of their 128-bit product, with `ovf` 0.
- R5: Code 0x40 (checked half-word multiply) returns the same result as R2. `ovf` is 1 unless bits 63:31 of the signed 64-bit product are all zeros or all ones.
- R6: Code 0x60 (checked full-word multiply) returns the same result as R3. `ovf` is 1 unless bits 127:63 of the signed 128-bit product are all zeros or all ones.
- R7: When `start` is sampled high while `busy` is low, `busy` is high from the next cycle. `done` is then high for exactly one cycle, WIDTH+1 clock edges after the accepting edge, and `busy` is low in that cycle.
- R8: A `start` pulse while `busy` is high is ignored. The operation in flight returns its own result, and no extra `done` follows.
- R9: `result` and `ovf` keep their values from one `done` to the next, whatever the inputs do in between.
- R10: Any other code returns bits 63:0 of the product with `ovf` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation; sampled only when idle |
| func | input | 7 | Operation code |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when `result` and `ovf` are updated |
| result | output | 64 | Selected part of the product |
| ovf | output | 1 | Overflow flag of the checked forms |

## Verification
The bench uses the default WIDTH of 64. At that width the operands are the real full words, so the double-width product and its overflow bits can be compared directly against 128-bit reference arithmetic. The most negative value, the largest positive value, minus one, zero, one and the half-word extremes therefore reach the boundaries of both overflow checks and the sign correction of the magnitude engine. The 65-cycle latency is short enough to check several hundred operations, each with its exact `done` timing.

// File: rtl/imul_pkg.sv
package imul_pkg;
  localparam int FUNC_W = 7;

  localparam logic [FUNC_W-1:0] OP_MULHW  = 7'h00;
  localparam logic [FUNC_W-1:0] OP_MULW   = 7'h20;
  localparam logic [FUNC_W-1:0] OP_UMULHI = 7'h30;
  localparam logic [FUNC_W-1:0] OP_MULHWC = 7'h40;
  localparam logic [FUNC_W-1:0] OP_MULWC  = 7'h60;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } mul_strobe_t;
endpackage

// File: rtl/imul_ctrl.sv
module imul_ctrl
  import imul_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output mul_strobe_t strobe,
  output logic        busy,
  output logic        done
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  state_t stateQ;
  logic [CW-1:0] cntQ;
  logic doneQ;

  always_comb begin
    strobe.load   = (stateQ == S_IDLE) && start;
    strobe.step   = (stateQ == S_RUN);
    strobe.finish = (stateQ == S_FIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      cntQ   <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= (stateQ == S_FIN);
      unique case (stateQ)
        S_IDLE: if (start) begin
          stateQ <= S_RUN;
          cntQ   <= '0;
        end
        S_RUN: begin
          cntQ <= cntQ + 1'b1;
          if (cntQ == LAST) stateQ <= S_FIN;
        end
        S_FIN:   stateQ <= S_IDLE;
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  assign busy = (stateQ != S_IDLE);
  assign done = doneQ;

  // R7: done lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R7: busy is low in the done cycle
  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R8: a running operation advances one step per cycle, whatever start does
  a_r8_run_advances: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_RUN && cntQ != LAST) |=> (stateQ == S_RUN && cntQ == $past(cntQ) + 1'b1));
endmodule

// File: rtl/imul_dpath.sv
module imul_dpath
  import imul_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  mul_strobe_t       strobe,
  input  logic [FUNC_W-1:0] funcIn,
  input  logic [WIDTH-1:0]  aIn,
  input  logic [WIDTH-1:0]  bIn,
  output logic [WIDTH-1:0]  result,
  output logic              ovf
);
  localparam int HALF = WIDTH / 2;
  localparam int PW   = 2 * WIDTH;

  logic [FUNC_W-1:0] funcQ;
  logic [WIDTH-1:0]  mcandQ, hiQ, loQ, resQ;
  logic              negQ, ovfQ;

  // operand conditioning
  logic              isHalf, signedOp, aNeg, bNeg;
  logic [WIDTH-1:0]  extA, extB, magA, magB;

  always_comb begin
    isHalf   = (funcIn == OP_MULHW) || (funcIn == OP_MULHWC);
    signedOp = (funcIn != OP_UMULHI);
    extA     = isHalf ? {{HALF{aIn[HALF-1]}}, aIn[HALF-1:0]} : aIn;
    extB     = isHalf ? {{HALF{bIn[HALF-1]}}, bIn[HALF-1:0]} : bIn;
    aNeg     = signedOp && extA[WIDTH-1];
    bNeg     = signedOp && extB[WIDTH-1];
    magA     = aNeg ? (WIDTH'(0) - extA) : extA;
    magB     = bNeg ? (WIDTH'(0) - extB) : extB;
  end

  // one shift-add step
  logic [WIDTH:0] sum;
  always_comb sum = {1'b0, hiQ} + (loQ[0] ? {1'b0, mcandQ} : '0);

  // final sign fix and selection
  logic [PW-1:0]   prod;
  logic [HALF:0]   halfTop;
  logic [WIDTH:0]  wordTop;
  logic            halfOvf, wordOvf;
  logic [WIDTH-1:0] nextRes;
  logic            nextOvf;

  always_comb begin
    prod    = negQ ? (PW'(0) - {hiQ, loQ}) : {hiQ, loQ};
    halfTop = prod[WIDTH-1:HALF-1];
    wordTop = prod[PW-1:WIDTH-1];
    halfOvf = !((&halfTop) || !(|halfTop));
    wordOvf = !((&wordTop) || !(|wordTop));
    nextOvf = 1'b0;
    unique case (funcQ)
      OP_MULHW:  nextRes = {{HALF{prod[HALF-1]}}, prod[HALF-1:0]};
      OP_MULHWC: begin
        nextRes = {{HALF{prod[HALF-1]}}, prod[HALF-1:0]};
        nextOvf = halfOvf;
      end
      OP_UMULHI: nextRes = prod[PW-1:WIDTH];
      OP_MULWC: begin
        nextRes = prod[WIDTH-1:0];
        nextOvf = wordOvf;
      end
      default:   nextRes = prod[WIDTH-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      funcQ  <= '0;
      mcandQ <= '0;
      hiQ    <= '0;
      loQ    <= '0;
      negQ   <= 1'b0;
      resQ   <= '0;
      ovfQ   <= 1'b0;
    end else begin
      if (strobe.load) begin
        funcQ  <= funcIn;
        mcandQ <= magA;
        hiQ    <= '0;
        loQ    <= magB;
        negQ   <= aNeg ^ bNeg;
      end else if (strobe.step) begin
        hiQ <= sum[WIDTH:1];
        loQ <= {sum[0], loQ[WIDTH-1:1]};
      end
      if (strobe.finish) begin
        resQ <= nextRes;
        ovfQ <= nextOvf;
      end
    end
  end

  assign result = resQ;
  assign ovf    = ovfQ;

  // R9: outputs change only on a finish step
  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> ($stable(result) && $stable(ovf)));
  // R10: only the checked codes can flag overflow
  a_r10_ovf_checked_only: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && funcQ != OP_MULHWC && funcQ != OP_MULWC) |=> !ovf);
  // R8: the operand registers do not reload during a run
  a_r8_no_reload: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |=> $stable(mcandQ) && $stable(funcQ));
endmodule

// File: rtl/imul_iter.sv
module imul_iter
  import imul_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [FUNC_W-1:0] func,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  output logic              busy,
  output logic              done,
  output logic [WIDTH-1:0]  result,
  output logic              ovf
);
  mul_strobe_t strobe;

  imul_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .busy   (busy),
    .done   (done)
  );

  imul_dpath #(.WIDTH(WIDTH)) uDpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .funcIn (func),
    .aIn    (opA),
    .bIn    (opB),
    .result (result),
    .ovf    (ovf)
  );

  // R7: an accepted start makes the block busy in the next cycle
  a_r7_busy_follows: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  // R1: no done while idle without a prior operation finishing
  a_r1_done_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !done) |=> !done);
endmodule

// File: tb/imul_iter_test.sv
module imul_iter_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [6:0]    func = '0;
  logic [W-1:0]  opA = '0, opB = '0;
  logic          busy, done, ovf;
  logic [W-1:0]  result;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  imul_iter #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .start(start), .func(func),
    .opA(opA), .opB(opB), .busy(busy), .done(done),
    .result(result), .ovf(ovf)
  );

  function automatic string tagFor(input logic [6:0] f);
    case (f)
      7'h00:   return "R2";
      7'h20:   return "R3";
      7'h30:   return "R4";
      7'h40:   return "R5";
      7'h60:   return "R6";
      default: return "R10";
    endcase
  endfunction

  function automatic void refModel(input logic [6:0] f, input logic [63:0] a,
                                   input logic [63:0] b,
                                   output logic [63:0] res, output logic ov);
    logic [127:0] p;
    logic [127:0] sa, sb;
    ov = 1'b0;
    if (f == 7'h00 || f == 7'h40) begin
      sa = {{96{a[31]}}, a[31:0]};
      sb = {{96{b[31]}}, b[31:0]};
      p = sa * sb;
      res = {{32{p[31]}}, p[31:0]};
      if (f == 7'h40) ov = !(p[63:31] == '0 || p[63:31] == '1);
    end else if (f == 7'h30) begin
      p = {64'b0, a} * {64'b0, b};
      res = p[127:64];
    end else begin
      sa = {{64{a[63]}}, a};
      sb = {{64{b[63]}}, b};
      p = sa * sb;
      res = p[63:0];
      if (f == 7'h60) ov = !(p[127:63] == '0 || p[127:63] == '1);
    end
  endfunction

  task automatic check64(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // apply one operation and check latency, result and flag
  task automatic runOp(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] eRes;
    logic eOv;
    int cyc;
    refModel(f, a, b, eRes, eOv);
    @(negedge clk);
    func = f; opA = a; opB = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check64("R7", "busy after start", {63'b0, busy}, 64'd1);
    cyc = 0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
    check64("R7", "done latency", 64'(cyc), 64'(W + 1));
    check64("R7", "busy low at done", {63'b0, busy}, 64'd0);
    check64(tagFor(f), "result", result, eRes);
    check64(tagFor(f), "overflow", {63'b0, ovf}, {63'b0, eOv});
    @(negedge clk);
    check64("R7", "done one cycle", {63'b0, done}, 64'd0);
  endtask

  logic [63:0] corners [5];
  logic [6:0]  codes [5];

  initial begin
    corners[0] = 64'h0;
    corners[1] = 64'h1;
    corners[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    corners[3] = 64'h8000_0000_0000_0000;
    corners[4] = 64'h7FFF_FFFF_FFFF_FFFF;
    codes[0] = 7'h00; codes[1] = 7'h20; codes[2] = 7'h30;
    codes[3] = 7'h40; codes[4] = 7'h60;
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int seed;
    logic [63:0] eRes, hRes;
    logic eOv, hOv;
    int sawDone;
    seed = 32'h5eed_1234;
    void'($urandom(seed));

    // R1: reset state
    repeat (3) @(negedge clk);
    check64("R1", "busy in reset", {63'b0, busy}, 64'd0);
    check64("R1", "result in reset", result, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check64("R1", "done after reset", {63'b0, done}, 64'd0);
    check64("R1", "ovf after reset", {63'b0, ovf}, 64'd0);
    check64("R1", "result after reset", result, 64'd0);

    // directed corner pairs over all codes
    for (int c = 0; c < 5; c++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          runOp(codes[c], corners[i], corners[j]);

    // half-word extremes for the checked half-word form (R5)
    runOp(7'h40, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000);
    runOp(7'h40, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_0000_0001);
    runOp(7'h40, 64'h0000_0000_0001_0000, 64'h0000_0000_0000_8000);
    runOp(7'h40, 64'h1234_5678_FFFF_FFFF, 64'hABCD_0000_8000_0000);
    // R10: unrecognized codes
    runOp(7'h11, 64'hFFFF_FFFF_FFFF_FFFE, 64'h0000_0000_0000_0003);
    runOp(7'h7F, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000);

    // random mix
    for (int k = 0; k < 160; k++) begin
      logic [63:0] a, b;
      logic [6:0] f;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (k % 4 == 1) a = a >> ($urandom % 64);
      if (k % 4 == 2) b = {{32{b[31]}}, b[31:0]};
      f = (k % 9 == 8) ? 7'($urandom) : codes[$urandom % 5];
      runOp(f, a, b);
    end

    // R8: start while busy is ignored
    refModel(7'h60, 64'h0000_0001_0000_0001, 64'h7FFF_FFFF_0000_0003, eRes, eOv);
    @(negedge clk);
    func = 7'h60; opA = 64'h0000_0001_0000_0001; opB = 64'h7FFF_FFFF_0000_0003; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    func = 7'h30; opA = '1; opB = '1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    sawDone = 0;
    for (int t = 0; t < 140; t++) begin
      if (done) begin
        sawDone++;
        if (sawDone == 1) begin
          check64("R8", "in-flight result kept", result, eRes);
          check64("R8", "in-flight ovf kept", {63'b0, ovf}, {63'b0, eOv});
        end
      end
      @(negedge clk);
    end
    check64("R8", "single done", 64'(sawDone), 64'd1);
    check64("R8", "idle after", {63'b0, busy}, 64'd0);

    // R9: outputs hold while inputs wander without start
    hRes = result; hOv = ovf;
    for (int t = 0; t < 20; t++) begin
      func = 7'($urandom); opA = {$urandom, $urandom}; opB = {$urandom, $urandom};
      @(negedge clk);
    end
    check64("R9", "result held", result, hRes);
    check64("R9", "ovf held", {63'b0, ovf}, {63'b0, hOv});
    check64("R9", "no done", {63'b0, done}, 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule